// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block runs a successive-approximation converter that delivers one 10-bit result over a single serial data line per 14-clock frame. From the fast system clock it derives the converter clock and drives the active-low start strobe. It samples the returning data line a programmable number of system clocks after each converter-clock falling edge. It shifts the ten bits in MSB first and offers the finished word on a valid/ready output.

A two-bit mode input, sampled when a run starts, picks one of three ways of driving the strobe. In single-shot mode each request gives exactly one frame, after which the converter clock stops. In synchronized mode the strobe is released early in every frame and lowered again at the end of the frame while the request is held, so frames follow each other with no gap. In free-run mode the strobe is held low and frames repeat until the request is withdrawn.

Top module: `adc_capture_host`

## Requirements
- R1: After reset the strobe `adc_start_n_o` is high, `adc_sclk_o` is low and `res_valid_o` is low.
- R2: While a frame runs, each converter-clock period is DIV system clocks, with the high phase ceil(DIV/2) and the low phase floor(DIV/2) clocks long. Outside frames the converter clock stays low.
- R3: A frame starts only with the strobe low. The strobe falls at least one system clock before the first rising converter-clock edge, and every frame is exactly 14 converter-clock periods.
- R4: Bits are taken after the falling edges of frame clocks 4 to 13, MSB first. The result is the 10-bit straight-binary word, with the first bit in position 9.
- R5: Each bit is sampled cap_dly_i+1 system clocks after the converter-clock falling edge. Values above floor(DIV/2)-1 saturate to that limit, so the LSB is taken before clock 14 rises.
- R6: Single-shot (mode_i 0, and the unused code 3): a request seen while idle gives exactly one frame. The strobe rises at the rising edge of clock 2, so it is high at the falling edge of clock 14, and the converter clock then stops.
- R7: Synchronized (mode_i 1): the strobe rises at the clock 2 rising edge and, while go_i is high, falls again at the falling edge of clock 14. The next frame then begins on the next rising edge, so frame starts are 14*DIV system clocks apart.
- R8: Free-run (mode_i 2): the strobe stays low from frame to frame. At the clock 2 rising edge it is released only if go_i is low, which makes that frame the last. Frame starts are 14*DIV system clocks apart.
- R9: `res_valid_o` and `res_data_o` hold until `res_ready_i` is high. A result that completes while the previous one is still waiting is discarded, and the older word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Run mode: 0/3 single-shot, 1 synchronized, 2 free-run |
| go_i | input | 1 | Conversion request |
| cap_dly_i | input | CAP_W | Sample delay in system clocks after a converter-clock fall |
| adc_sclk_o | output | 1 | Converter clock |
| adc_start_n_o | output | 1 | Active-low start strobe |
| adc_sdata_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | Result available |
| res_data_o | output | DATA_W | Assembled result |
| res_ready_i | input | 1 | Result accepted |

## Verification
The bench builds the block with DIV = 7 and CAP_W = 3. The odd divider gives unequal phases (four high, three low), so the phase-balance rule and the one-clock imbalance are checked directly. The short three-clock low phase puts a sample delay of 2 right against the LSB window, and a delay of 6 lies well outside it. This exercises the saturation, because an unclamped sample would land on the corrupted data that the converter model drives from the clock 14 rising edge.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_SYNC   = 2'd1,
      MODE_FREE   = 2'd2
   } run_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_RUN  = 2'd2
   } seq_state_e;

   function automatic run_mode_e decode_mode(input logic [1:0] code);
      case (code)
         2'd1:    return MODE_SYNC;
         2'd2:    return MODE_FREE;
         default: return MODE_SINGLE;
      endcase
   endfunction

endpackage

// File: rtl/adc_host_clkgen.sv
module adc_host_clkgen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic sclk_o,
   output logic wrap_o,
   output logic fall_next_o,
   output logic fall_o
);
   localparam int HI   = DIV - DIV / 2;
   localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

   logic            active_q;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_n;
   logic            sclk_q;
   logic            fall_q;

   generate
      if (DIV == 2) begin : g_toggle
         always_comb ph_n = active_q ? ~ph_q : '0;
      end else begin : g_count
         always_comb begin
            if (!active_q || ph_q == PH_W'(DIV - 1)) ph_n = '0;
            else                                    ph_n = ph_q + PH_W'(1);
         end
      end
   endgenerate

   always_comb begin
      wrap_o      = active_q && (ph_q == PH_W'(DIV - 1));
      fall_next_o = active_q && (ph_q == PH_W'(HI - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ph_q     <= '0;
         sclk_q   <= 1'b0;
         fall_q   <= 1'b0;
      end else begin
         active_q <= en_i;
         ph_q     <= en_i ? ph_n : '0;
         sclk_q   <= en_i && (ph_n < PH_W'(HI));
         fall_q   <= en_i && fall_next_o;
      end
   end

   assign sclk_o = sclk_q;
   assign fall_o = fall_q;

   // R2: the cycle flagged as the first low cycle really is low
   p_fall_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> !sclk_o);
   // R2: the converter clock never rises while the divider is stopped
   p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !en_i) |=> !sclk_o);
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
   import adc_host_pkg::*;
#(
   parameter int DIV           = 4,
   parameter int DATA_W        = 10,
   parameter int FRAME_CLKS    = 14,
   parameter int FIRST_BIT_CLK = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       go_i,
   input  logic       sclk_i,
   input  logic       wrap_i,
   input  logic       fall_next_i,
   input  logic       fall_i,
   output logic       en_o,
   output logic       start_n_o,
   output logic       bit_fall_o,
   output logic       last_bit_o
);
   localparam int LO       = DIV / 2;
   localparam int CNT_W    = $clog2(FRAME_CLKS + 1);
   localparam int LAST_CLK = FIRST_BIT_CLK + DATA_W - 1;

   seq_state_e       st_q;
   run_mode_e        mode_q;
   logic [CNT_W-1:0] cnum_q;
   logic             scn_q;
   logic             bit_fall_q;
   logic             last_q;
   logic             frame_end;
   logic             in_bits;
   logic             drop_evt;

   // Re-lower the strobe one cycle after the clock 14 fall when the low phase allows it
   generate
      if (LO >= 2) begin : g_late_drop
         assign drop_evt = fall_i;
      end else begin : g_early_drop
         assign drop_evt = fall_next_i;
      end
   endgenerate

   always_comb begin
      frame_end = (st_q == ST_RUN) && wrap_i && (cnum_q == CNT_W'(FRAME_CLKS));
      en_o      = (st_q == ST_LEAD) || ((st_q == ST_RUN) && !(frame_end && scn_q));
      in_bits   = (cnum_q >= CNT_W'(FIRST_BIT_CLK)) && (cnum_q <= CNT_W'(LAST_CLK));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         mode_q     <= MODE_SINGLE;
         cnum_q     <= '0;
         scn_q      <= 1'b1;
         bit_fall_q <= 1'b0;
         last_q     <= 1'b0;
      end else begin
         bit_fall_q <= (st_q == ST_RUN) && fall_next_i && in_bits;
         last_q     <= (cnum_q == CNT_W'(LAST_CLK));
         case (st_q)
            ST_IDLE: begin
               if (go_i) begin
                  scn_q  <= 1'b0;
                  mode_q <= decode_mode(mode_i);
                  st_q   <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               st_q   <= ST_RUN;
               cnum_q <= CNT_W'(1);
            end
            ST_RUN: begin
               if (wrap_i) begin
                  if (cnum_q == CNT_W'(FRAME_CLKS)) begin
                     if (scn_q) st_q   <= ST_IDLE;
                     else       cnum_q <= CNT_W'(1);
                  end else begin
                     cnum_q <= cnum_q + CNT_W'(1);
                  end
                  if (cnum_q == CNT_W'(1))
                     scn_q <= (mode_q != MODE_FREE) || !go_i;
               end
               if (drop_evt && (cnum_q == CNT_W'(FRAME_CLKS)) &&
                   (mode_q == MODE_SYNC) && go_i)
                  scn_q <= 1'b0;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign start_n_o  = scn_q;
   assign bit_fall_o = bit_fall_q;
   assign last_bit_o = last_q;

   // R3: during clock 1 of any frame the strobe is low
   p_start_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_RUN) && (cnum_q == CNT_W'(1)) && sclk_i) |-> !scn_q);
   // R6: single-shot strobe is already high at the clock 14 fall
   p_single_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && (st_q == ST_RUN) && (cnum_q == CNT_W'(FRAME_CLKS)) &&
       (mode_q == MODE_SINGLE)) |-> scn_q);
   // R7: a chained frame rises on the very next system clock
   p_chain_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !scn_q) |=> sclk_i);
   // R8: in free-run the strobe moves only on entry to clock 2
   p_free_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_RUN) && $past(st_q == ST_RUN) && (mode_q == MODE_FREE) &&
       (cnum_q != CNT_W'(2))) |-> $stable(scn_q));
endmodule

// File: rtl/adc_host_capture.sv
module adc_host_capture #(
   parameter int DATA_W = 10,
   parameter int CAP_W  = 4,
   parameter int LO     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_fall_i,
   input  logic              last_i,
   input  logic [CAP_W-1:0]  cap_dly_i,
   input  logic              sdata_i,
   input  logic              sclk_i,
   input  logic              res_ready_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_data_o
);
   localparam int MAXD = LO - 1;

   logic [CAP_W-1:0]  dly_eff;
   logic [CAP_W-1:0]  cnt_q;
   logic              pend_q;
   logic              last_pend_q;
   logic [DATA_W-1:0] sh_q;
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              smp;
   logic              smp_last;
   logic              done;
   logic [DATA_W-1:0] word;

   always_comb begin
      dly_eff  = (32'(cap_dly_i) > MAXD) ? CAP_W'(MAXD) : cap_dly_i;
      smp      = (bit_fall_i && (dly_eff == '0)) || (pend_q && (cnt_q == '0));
      smp_last = bit_fall_i ? last_i : last_pend_q;
      done     = smp && smp_last;
      word     = {sh_q[DATA_W-2:0], sdata_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         cnt_q       <= '0;
         last_pend_q <= 1'b0;
         sh_q        <= '0;
      end else begin
         if (bit_fall_i) begin
            pend_q      <= (dly_eff != '0);
            cnt_q       <= dly_eff - CAP_W'(1);
            last_pend_q <= last_i;
         end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - CAP_W'(1);
         end
         if (smp) sh_q <= word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         if (valid_q && res_ready_i) valid_q <= 1'b0;
         if (done && (!valid_q || res_ready_i)) begin
            valid_q <= 1'b1;
            data_q  <= word;
         end
      end
   end

   assign res_valid_o = valid_q;
   assign res_data_o  = data_q;

   // R5: every sample falls inside the converter-clock low phase
   p_sample_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      smp |-> !sclk_i);
   // R9: an unaccepted result stays put
   p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));
endmodule

// File: rtl/adc_capture_host.sv
module adc_capture_host #(
   parameter int DIV           = 4,
   parameter int DATA_W        = 10,
   parameter int FRAME_CLKS    = 14,
   parameter int FIRST_BIT_CLK = 4,
   parameter int CAP_W         = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              go_i,
   input  logic [CAP_W-1:0]  cap_dly_i,
   output logic              adc_sclk_o,
   output logic              adc_start_n_o,
   input  logic              adc_sdata_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_data_o,
   input  logic              res_ready_i
);
   localparam int LO = DIV / 2;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("DIV must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (FIRST_BIT_CLK + DATA_W > FRAME_CLKS) begin : g_bad_frame
         $error("last bit must fall before the final frame clock");
      end
      if (CAP_W < 1) begin : g_bad_cap
         $error("CAP_W must be at least 1");
      end
   endgenerate

   logic en, wrap, fall_next, fall, bit_fall, last_bit;

   adc_host_clkgen #(.DIV(DIV)) i_clkgen (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en),
      .sclk_o      (adc_sclk_o),
      .wrap_o      (wrap),
      .fall_next_o (fall_next),
      .fall_o      (fall)
   );

   adc_host_seq #(
      .DIV           (DIV),
      .DATA_W        (DATA_W),
      .FRAME_CLKS    (FRAME_CLKS),
      .FIRST_BIT_CLK (FIRST_BIT_CLK)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .go_i        (go_i),
      .sclk_i      (adc_sclk_o),
      .wrap_i      (wrap),
      .fall_next_i (fall_next),
      .fall_i      (fall),
      .en_o        (en),
      .start_n_o   (adc_start_n_o),
      .bit_fall_o  (bit_fall),
      .last_bit_o  (last_bit)
   );

   adc_host_capture #(
      .DATA_W (DATA_W),
      .CAP_W  (CAP_W),
      .LO     (LO)
   ) i_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_fall_i  (bit_fall),
      .last_i      (last_bit),
      .cap_dly_i   (cap_dly_i),
      .sdata_i     (adc_sdata_i),
      .sclk_i      (adc_sclk_o),
      .res_ready_i (res_ready_i),
      .res_valid_o (res_valid_o),
      .res_data_o  (res_data_o)
   );
endmodule

// File: tb/test_adc_capture_host.sv
`timescale 1ns/1ps
module test_adc_capture_host;
   localparam int DIV = 7;
   localparam int HI  = DIV - DIV / 2;
   localparam int FRM = 14 * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       go = 1'b0;
   logic [2:0] cap_dly = 3'd1;
   logic       adc_sclk, adc_start_n, res_valid, ready = 1'b1;
   logic       adc_sdata = 1'b0;
   logic [9:0] res_data;

   int  tests = 0, fails = 0, cyc = 0;
   bit  fin = 1'b0;
   string cur_req = "R4";

   logic [9:0] mdl_q[$];
   logic [9:0] exp_q[$];
   int  start_cyc[$];
   int  mdl_cnt = 14, last_rise = 0, total_rises = 0;
   logic [9:0] mdl_word = '0;
   int  err_clk = 0, err_proto = 0, err_single = 0, hi_run = 0, scn_rises = 0;
   bit  single_mode = 1'b1;
   logic scn_prev = 1'b1;

   always #4 clk = ~clk;

   adc_capture_host #(.DIV(DIV), .CAP_W(3)) i_adc_capture_host (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .go_i(go), .cap_dly_i(cap_dly),
      .adc_sclk_o(adc_sclk), .adc_start_n_o(adc_start_n), .adc_sdata_i(adc_sdata),
      .res_valid_o(res_valid), .res_data_o(res_data), .res_ready_i(ready));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // converter model
   always @(posedge adc_sclk) begin
      total_rises++;
      if (mdl_cnt < 14) begin
         if (cyc - last_rise != DIV) err_clk++;
         last_rise = cyc;
         mdl_cnt++;
         if (mdl_cnt == 14) begin
            #1 adc_sdata = ~adc_sdata;
         end
      end else if (adc_start_n) begin
         err_proto++;
         last_rise = cyc;
      end else begin
         last_rise = cyc;
         mdl_cnt = 1;
         start_cyc.push_back(cyc);
         adc_sdata = 1'b0;
         if (mdl_q.size() == 0) begin
            chk(0, "R6 unrequested frame", 0, 1);
            mdl_word = '0;
         end else mdl_word = mdl_q.pop_front();
      end
   end

   always @(negedge adc_sclk) begin
      int c;
      c = mdl_cnt;
      if (c == 14 && single_mode && !adc_start_n) err_single++;
      if (c >= 4 && c <= 13) begin
         #9 adc_sdata = mdl_word[13 - c];
      end
   end

   // scoreboard monitor and edge bookkeeping
   always @(negedge clk) begin
      if (rst_n) begin
         if (adc_sclk) hi_run++;
         else if (hi_run != 0) begin
            if (hi_run != HI) err_clk++;
            hi_run = 0;
         end
         if (adc_start_n && !scn_prev) scn_rises++;
         scn_prev = adc_start_n;
         if (res_valid && ready) begin
            if (exp_q.size() == 0) chk(0, {cur_req, " unexpected result"}, int'(res_data), 0);
            else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               chk(res_data == e, {cur_req, " result word"}, int'(res_data), int'(e));
            end
         end
      end
   end

   task automatic push_val(input logic [9:0] v, input bit expect_out);
      mdl_q.push_back(v);
      if (expect_out) exp_q.push_back(v);
   endtask

   task automatic pulse_go;
      @(negedge clk) go = 1'b1;
      @(negedge clk) go = 1'b0;
   endtask

   task automatic drain;
      int k;
      k = 0;
      while ((exp_q.size() != 0 || mdl_cnt < 14 || mdl_q.size() != 0) && k < 5000) begin
         @(negedge clk);
         k++;
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic burst(input logic [1:0] m, input string req);
      int base, r0, k;
      mode = m;
      single_mode = 1'b0;
      for (int i = 0; i < 3; i++) push_val(10'h0F0 + 10'(i * 37), 1'b1);
      base = start_cyc.size();
      r0 = scn_rises;
      @(negedge clk) go = 1'b1;
      k = 0;
      while (start_cyc.size() < base + 3 && k < 3000) begin
         @(negedge clk);
         k++;
      end
      go = 1'b0;
      drain();
      chk(start_cyc.size() == base + 3, {req, " frame count"}, start_cyc.size() - base, 3);
      if (start_cyc.size() >= base + 3) begin
         chk(start_cyc[base+1] - start_cyc[base] == FRM, {req, " back-to-back spacing 1"},
             start_cyc[base+1] - start_cyc[base], FRM);
         chk(start_cyc[base+2] - start_cyc[base+1] == FRM, {req, " back-to-back spacing 2"},
             start_cyc[base+2] - start_cyc[base+1], FRM);
      end
      chk(scn_rises - r0 == ((m == 2'd2) ? 1 : 3), {req, " strobe releases"},
          scn_rises - r0, (m == 2'd2) ? 1 : 3);
      single_mode = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog R3 act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [9:0] pats[5];
      int r0;
      pats = '{10'h2AA, 10'h155, 10'h3FF, 10'h000, 10'h201};
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(adc_start_n == 1'b1, "R1 strobe high in reset", adc_start_n, 1);
      chk(adc_sclk == 1'b0, "R1 clock low in reset", adc_sclk, 0);
      chk(res_valid == 1'b0, "R1 valid low in reset", res_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(adc_start_n == 1'b1 && adc_sclk == 1'b0, "R1 idle after reset",
          {adc_start_n, adc_sclk}, 2'b10);

      // R4 / R6: single-shot frames, several patterns
      cur_req = "R4";
      r0 = total_rises;
      foreach (pats[i]) begin
         push_val(pats[i], 1'b1);
         pulse_go();
         drain();
      end
      chk(total_rises - r0 == 14 * 5, "R6 clock stops after each single frame",
          total_rises - r0, 70);

      // R6: unused mode code 3 behaves as single-shot
      cur_req = "R6";
      mode = 2'd3;
      push_val(10'h0C3, 1'b1);
      pulse_go();
      drain();
      mode = 2'd0;

      // R5: delay at the edge of the window and saturated delay
      cur_req = "R5";
      cap_dly = 3'd2;
      push_val(10'h1C3, 1'b1);
      pulse_go();
      drain();
      cap_dly = 3'd6;
      push_val(10'h3A5, 1'b1);
      push_val(10'h05A, 1'b1);
      pulse_go();
      drain();
      pulse_go();
      drain();
      cap_dly = 3'd1;

      // R7 and R8: chained runs
      cur_req = "R7";
      burst(2'd1, "R7");
      cur_req = "R8";
      burst(2'd2, "R8");

      // R9: a result finishing while the previous one waits is dropped
      cur_req = "R9";
      mode = 2'd0;
      ready = 1'b0;
      push_val(10'h2D4, 1'b1);
      push_val(10'h13B, 1'b0);
      pulse_go();
      drain();
      chk(res_valid == 1'b1, "R9 valid held without ready", res_valid, 1);
      pulse_go();
      repeat (FRM + 40) @(negedge clk);
      chk(res_valid == 1'b1, "R9 valid still held", res_valid, 1);
      chk(res_data == 10'h2D4, "R9 older result kept", int'(res_data), 10'h2D4);
      ready = 1'b1;
      drain();
      chk(exp_q.size() == 0, "R9 kept result delivered", exp_q.size(), 0);

      // R2 / R3 / R6 protocol counters
      chk(err_clk == 0, "R2 clock period and high phase", err_clk, 0);
      chk(err_proto == 0, "R3 clock rise with strobe high", err_proto, 0);
      chk(err_single == 0, "R6 strobe high at clock 14 fall", err_single, 0);
      chk(adc_sclk == 1'b0 && adc_start_n == 1'b1, "R2 idle at end",
          {adc_sclk, adc_start_n}, 2'b01);

      fin = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule